// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects eight interrupt inputs and decides which one the processor should service next. It keeps three eight-bit registers: pending requests, levels in service and a mask. Priority is fixed, and input 0 ranks highest. When an eligible request exists, the controller raises a single interrupt line. When the processor pulses acknowledge, the block returns a vector byte on that same cycle. The vector is a programmable base plus the level number.

Software drives the block through a small byte port with three addresses. The command address carries these commands:
- the initialization trigger;
- the readback selector;
- specific end-of-interrupt.

The data address has two roles. During initialization it takes three configuration words. At all other times it reads and writes the mask. A third address holds a per-input register that picks edge or level capture.

Two more behaviours are configurable:
- **Auto end-of-interrupt.** An option in the mode word stops the in-service bit from being set on acknowledge.
- **Spurious acknowledge.** An acknowledge that finds no eligible request returns the vector for level 7 and changes nothing else.

Top module: `pic8_core`

## Requirements
- R1: After reset: pending and in-service registers are 0x00, the mask is 0xFF, command-address reads return the pending register, `int_out` is low, and the controller is uninitialized.
- R2: A command write with bit 4 set starts initialization. That write clears the pending register, the in-service register and the mask to 0x00, and resets the readback selection to pending. The next three data-address writes are taken in order as vector base, cascade word and mode word; none of them changes the mask. `int_out` stays low until the mode word has been written.
- R3: During an `inta` cycle with an eligible request, `vec_out` equals the vector base plus the winning level number (modulo 256).
- R4: `cascade_cfg` presents the cascade word from the most recent initialization.
- R5: Outside initialization, a data-address write loads the mask, and a data-address read returns exactly that value. A masked input (mask bit 1) is never granted.
- R6: Command byte 0x0A selects the pending register for command-address reads. Command byte 0x0B selects the in-service register. The selection holds until another such command arrives.
- R7: Level 0 has the highest priority and level 7 the lowest. A request is eligible only when it is unmasked and no in-service bit at the same or a higher-priority level is set. `int_out` is high exactly when the controller is initialized and an eligible request exists.
- R8: In normal mode, an acknowledge sets the in-service bit of the granted level. For an edge-captured input it also clears that level's pending bit.
- R9: Command byte 0x60+n (n = 0..7) clears in-service bit n only.
- R10: When mode-word bit 1 is 1 (auto end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R11: An acknowledge with no eligible request returns base+7 and leaves the in-service register unchanged. This holds even when level 7 is masked.
- R12: Trigger register bit n selects how input n is captured. With 0 (edge), a rising edge sets the pending bit, and the bit holds after the input falls. With 1 (level), the pending bit follows the input with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; `rdata` is valid on the following cycle |
| addr | input | 2 | 0 = command, 1 = data/mask, 2 = trigger select, 3 = unused (reads 0) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| irq_in | input | 8 | Interrupt request inputs |
| inta | input | 1 | Single-cycle acknowledge strobe |
| int_out | output | 1 | Registered interrupt request to the processor |
| vec_out | output | 8 | Vector byte, valid in the `inta` cycle, zero otherwise |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
The assertions check the following on every cycle:
- the post-reset register state;
- that `int_out` stays low while the controller is uninitialized;
- that a granted level is never masked;
- that a specific end-of-interrupt clears its bit;
- that the in-service register is left untouched by auto end-of-interrupt and by spurious acknowledges.

The bench scenarios show what a single cycle cannot:
- the order of the initialization words;
- vector arithmetic across several request and mask patterns;
- nesting, where one in-service level blocks lower levels until its end-of-interrupt;
- persistence of the readback selection;
- the difference between edge and level capture when an input falls before acknowledge.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_CASC, ST_MODE} init_st_t;
  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_TRIG = 2'd2;
endpackage

// File: rtl/pic8_prog.sv
module pic8_prog
  import pic8_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  output logic [N-1:0]  imr,
  output logic [N-1:0]  trig,
  output logic [7:0]    vbase,
  output logic [7:0]    casc,
  output logic          aeoi,
  output logic          rd_isr,
  output logic          ready,
  output logic          init_clr,
  output logic          eoi_valid,
  output logic [LW-1:0] eoi_lvl
);
  init_st_t st;
  logic cmd_wr, dat_wr, sel_cmd;

  assign cmd_wr    = wr_en && (addr == A_CMD);
  assign dat_wr    = wr_en && (addr == A_DATA);
  assign init_clr  = cmd_wr && wdata[4];
  assign sel_cmd   = cmd_wr && (wdata[7:1] == 7'b0000101);
  assign eoi_valid = cmd_wr && (wdata[7:3] == 5'b01100);
  assign eoi_lvl   = wdata[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ready  <= 1'b0;
      imr    <= '1;
      trig   <= '0;
      vbase  <= '0;
      casc   <= '0;
      aeoi   <= 1'b0;
      rd_isr <= 1'b0;
    end else begin
      if (init_clr) begin
        st     <= ST_BASE;
        ready  <= 1'b0;
        imr    <= '0;
        rd_isr <= 1'b0;
      end else if (sel_cmd) begin
        rd_isr <= wdata[0];
      end
      if (dat_wr) begin
        case (st)
          ST_BASE: begin vbase <= wdata; st <= ST_CASC; end
          ST_CASC: begin casc  <= wdata; st <= ST_MODE; end
          ST_MODE: begin aeoi  <= wdata[1]; st <= ST_IDLE; ready <= 1'b1; end
          default: imr <= wdata[N-1:0];
        endcase
      end
      if (wr_en && addr == A_TRIG) trig <= wdata[N-1:0];
    end
  end

  p_reset_cfg_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (imr == '1 && !ready && !rd_isr));
  p_mode_done_r2: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && st == ST_MODE) |=> ready);
endmodule

// File: rtl/pic8_resolve.sv
module pic8_resolve #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  imr,
  input  logic [N-1:0]  isr,
  output logic          any,
  output logic [LW-1:0] lvl,
  output logic [N-1:0]  grant
);
  logic [N-1:0] elig;
  assign elig = req & ~imr;

  always_comb begin
    logic blk;
    blk = 1'b0;
    any = 1'b0;
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      blk = blk | isr[i];
      if (!any && elig[i] && !blk) begin
        any = 1'b1;
        lvl = LW'(i);
      end
    end
    grant = any ? (N'(1) << lvl) : '0;
  end
endmodule

// File: rtl/pic8_core.sv
module pic8_core
  import pic8_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic [N-1:0] irq_in,
  input  logic         inta,
  output logic         int_out,
  output logic [7:0]   vec_out,
  output logic [7:0]   cascade_cfg
);
  logic [N-1:0] imr, trig, irq_q, irr, isr, grant, eoi_oh, irr_n, isr_set;
  logic [7:0]   vbase;
  logic         aeoi, rd_isr, ready, init_clr, eoi_valid, any, ack_hit;
  logic [LW-1:0] eoi_lvl, lvl;

  pic8_prog #(.N(N), .LW(LW)) u_prog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .imr(imr), .trig(trig), .vbase(vbase), .casc(cascade_cfg), .aeoi(aeoi),
    .rd_isr(rd_isr), .ready(ready), .init_clr(init_clr),
    .eoi_valid(eoi_valid), .eoi_lvl(eoi_lvl));

  pic8_resolve #(.N(N), .LW(LW)) u_res (
    .req(irr), .imr(imr), .isr(isr), .any(any), .lvl(lvl), .grant(grant));

  assign ack_hit = inta && any;
  assign eoi_oh  = eoi_valid ? (N'(1) << eoi_lvl) : '0;
  assign isr_set = (ack_hit && !aeoi) ? grant : '0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_cap
      assign irr_n[i] = trig[i] ? irq_in[i]
                      : ((irr[i] | (irq_in[i] & ~irq_q[i])) & ~(ack_hit & grant[i]));
    end
  endgenerate

  always_comb begin
    vec_out = '0;
    if (inta) vec_out = vbase + (any ? 8'(lvl) : 8'(N - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= '0;
      irr     <= '0;
      isr     <= '0;
      int_out <= 1'b0;
      rdata   <= '0;
    end else begin
      irq_q   <= irq_in;
      irr     <= init_clr ? '0 : irr_n;
      isr     <= init_clr ? '0 : ((isr & ~eoi_oh) | isr_set);
      int_out <= ready && any;
      if (rd_en) begin
        rdata <= '0;
        case (addr)
          A_CMD:   rdata[N-1:0] <= rd_isr ? isr : irr;
          A_DATA:  rdata[N-1:0] <= imr;
          A_TRIG:  rdata[N-1:0] <= trig;
          default: rdata <= '0;
        endcase
      end
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irr == '0 && isr == '0 && !int_out));
  p_quiet_uninit_r2: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !int_out);
  p_grant_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
    ack_hit |-> ((grant & imr) == '0));
  p_eoi_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !ack_hit) |=> !isr[$past(eoi_lvl)]);
  p_aeoi_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (inta && aeoi && !eoi_valid && !init_clr) |=> (isr == $past(isr)));
  p_spurious_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (inta && !any && !eoi_valid && !init_clr) |=> (isr == $past(isr)));
endmodule

// File: tb/pic8_core_tb.sv
module pic8_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, inta = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vec_out, cascade_cfg;
  logic       int_out;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [23:0] TBL [5] = '{
    {8'h01, 8'h00, 8'h20},
    {8'h0C, 8'h00, 8'h22},
    {8'h0C, 8'h04, 8'h23},
    {8'h80, 8'h00, 8'h27},
    {8'hF0, 8'h30, 8'h26}
  };

  pic8_core u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .inta(inta),
    .int_out(int_out), .vec_out(vec_out), .cascade_cfg(cascade_cfg));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); inta = 1'b1; #1 v = vec_out;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); irq_in = irq_in | p;
    @(negedge clk); irq_in = irq_in & ~p;
  endtask

  task automatic init(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
    wr(0, 8'h11); wr(1, b); wr(1, c); wr(1, m);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v;
    idle(3); @(negedge clk); rst = 1'b0;
    // R1 reset state
    rd(0, d); chk("R1 pending", d, 8'h00);
    rd(1, d); chk("R1 mask", d, 8'hFF);
    chk("R1 int_out", {7'b0, int_out}, 8'h00);
    // R2 no interrupt before initialization
    wr(1, 8'h00); pulse(8'h01); idle(3);
    chk("R2 int before init", {7'b0, int_out}, 8'h00);
    // R2 R4 initialization words
    init(8'h40, 8'h04, 8'h01);
    chk("R4 cascade", cascade_cfg, 8'h04);
    rd(1, d); chk("R2 mask after init", d, 8'h00);
    rd(0, d); chk("R2 pending cleared", d, 8'h00);
    // R5 mask readback
    wr(1, 8'hA5); rd(1, d); chk("R5 mask readback", d, 8'hA5);
    // R3 R5 R7 table walk
    foreach (TBL[k]) begin
      init(8'h20, 8'h04, 8'h01);
      wr(1, TBL[k][15:8]);
      pulse(TBL[k][23:16]); idle(3);
      chk("R7 int_out table", {7'b0, int_out}, 8'h01);
      ack(v); chk("R3 vector table", v, TBL[k][7:0]);
    end
    // nesting, readback select, EOI
    init(8'h40, 8'h04, 8'h01);
    pulse(8'h08); idle(3);
    rd(0, d); chk("R12 edge held", d, 8'h08);
    ack(v); chk("R3 vector lvl3", v, 8'h43);
    idle(1);
    rd(0, d); chk("R8 pending cleared", d, 8'h00);
    wr(0, 8'h0B);
    rd(0, d); chk("R8 isr set", d, 8'h08);
    rd(0, d); chk("R6 select persists", d, 8'h08);
    pulse(8'h20); idle(3);
    chk("R7 lower blocked", {7'b0, int_out}, 8'h00);
    pulse(8'h02); idle(3);
    chk("R7 higher preempts", {7'b0, int_out}, 8'h01);
    ack(v); chk("R3 vector lvl1", v, 8'h41);
    rd(0, d); chk("R8 nested isr", d, 8'h0A);
    wr(0, 8'h61);
    rd(0, d); chk("R9 eoi lvl1 only", d, 8'h08);
    idle(3);
    chk("R7 still blocked", {7'b0, int_out}, 8'h00);
    wr(0, 8'h63); idle(3);
    chk("R7 unblocked", {7'b0, int_out}, 8'h01);
    ack(v); chk("R3 vector lvl5", v, 8'h45);
    wr(0, 8'h65);
    rd(0, d); chk("R9 isr empty", d, 8'h00);
    wr(0, 8'h0A);
    rd(0, d); chk("R6 pending select", d, 8'h00);
    // R12 level capture
    wr(2, 8'h08); rd(2, d); chk("R12 trig readback", d, 8'h08);
    @(negedge clk); irq_in[3] = 1'b1; idle(3);
    ack(v); chk("R3 level vector", v, 8'h43);
    rd(0, d); chk("R12 level stays pending", d, 8'h08);
    wr(0, 8'h0B); rd(0, d); chk("R8 level isr", d, 8'h08);
    wr(0, 8'h63);
    @(negedge clk); irq_in[3] = 1'b0; idle(3);
    wr(0, 8'h0A); rd(0, d); chk("R12 level follows", d, 8'h00);
    // R11 spurious: level request gone before ack
    @(negedge clk); irq_in[3] = 1'b1; idle(3);
    @(negedge clk); irq_in[3] = 1'b0; idle(2);
    ack(v); chk("R11 vanished vector", v, 8'h47);
    wr(0, 8'h0B); rd(0, d); chk("R11 isr untouched", d, 8'h00);
    // R11 spurious with all masked
    wr(1, 8'hFF); pulse(8'h04); idle(3);
    chk("R5 masked no int", {7'b0, int_out}, 8'h00);
    ack(v); chk("R11 masked vector", v, 8'h47);
    rd(0, d); chk("R11 isr still empty", d, 8'h00);
    // R10 auto end-of-interrupt
    init(8'h40, 8'h04, 8'h03);
    pulse(8'h10); idle(3);
    ack(v); chk("R10 vector", v, 8'h44);
    wr(0, 8'h0B); rd(0, d); chk("R10 isr not set", d, 8'h00);
    wr(0, 8'h0A); rd(0, d); chk("R10 pending cleared", d, 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule